// File: doc/BRIEF.md
# Handshake Join Barrier

This block merges the completion handshakes of several modules that run side by side into one completion handshake. A start pulse is sent to every branch at once. Each branch then reports that it has finished with a one-cycle done pulse, at any time and in any order. The barrier keeps each arrival in a private latch. When every latch holds an arrival, the barrier emits a single join pulse and empties all of its latches in that same step, which arms it for the next round.

The firing decision is a threshold test. Each latch adds a weight of one, a bias of minus (N-1) is added, and the barrier fires when the total reaches one. A group of N-1 set latches therefore never fires it. The join pulse is meant to be the start pulse of the next stage. The same block closes a group of sub-expressions that are evaluated together and also closes a parallel block of statements.

Top module: `join_barrier`

## Requirements
- R1: While rst_ni is low, and for as long as no done pulse arrives after it, join_o is 0 and every latch is empty. Reset may be applied in the middle of a round, and it discards the arrivals collected so far.
- R2: A done pulse on done_i[i], sampled on a rising clock edge, is held in latch i until the barrier fires. Arrivals may come in any order and with any gaps between them.
- R3: When the last empty latch is set at edge e, join_o is 1 for exactly the clock cycle that follows edge e+1.
- R4: The sum of the latches plus a bias of -(N-1) must be at least 1 for the barrier to fire. With N-1 or fewer latches set, join_o stays 0 however long the inputs wait.
- R5: The edge that fires the barrier clears every latch at once. The next join pulse needs a fresh arrival on all N inputs.
- R6: A done pulse that is sampled on the same edge at which the barrier fires is stored for the next round and is not lost.
- R7: A done pulse on an input whose latch is already set has no further effect within the current round. It produces no extra join pulse, and it does not count as an arrival for the next round.
- R8: start_o[i] equals start_i for every i, combinationally, so one start pulse reaches all N branches in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for the parallel group |
| start_o | output | N | Start pulse copied to each branch |
| done_i | input | N | One-cycle done pulse from each branch |
| join_o | output | 1 | One-cycle pulse when all branches have finished |

## Verification
Directed rounds feed arrivals one at a time with idle gaps, so that N-1 set latches can be told apart from N. A second pulse on an input that is already latched checks that repeats are not counted again. A done pulse placed on the exact firing edge separates a barrier that keeps it from one that loses it when the latches clear. After that, random done vectors, in which several inputs often assert together and with the fire cycle, are compared cycle by cycle against a bench model of the round state. A reset in the middle of a round shows that partial arrivals are discarded.

// File: rtl/join_pkg.sv
package join_pkg;
  // bias applied to the latch sum so only a full set reaches the threshold
  function automatic int join_bias(input int n);
    return -(n - 1);
  endfunction
  localparam int JOIN_THRESHOLD = 1;
endpackage

// File: rtl/join_latch.sv
module join_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // self-holding cell; a set on the clearing edge wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/join_thresh.sv
module join_thresh #(
  parameter int N = 4
) (
  input  logic [N-1:0] latch_i,
  output logic         fire_o
);
  import join_pkg::*;
  localparam int BIAS = join_bias(N);

  int acc;
  always_comb begin
    acc = BIAS;
    for (int k = 0; k < N; k++) acc += int'(latch_i[k]);
    fire_o = (acc >= JOIN_THRESHOLD);
  end
endmodule

// File: rtl/join_barrier.sv
module join_barrier #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  output logic [N-1:0] start_o,
  input  logic [N-1:0] done_i,
  output logic         join_o
);
  logic [N-1:0] latch_q;
  logic         fire_now;
  logic         join_q;

  assign start_o = {N{start_i}};

  for (genvar g = 0; g < N; g++) begin : g_lat
    join_latch u_lat (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (done_i[g]),
      .clr_i (fire_now),
      .q_o   (latch_q[g])
    );
  end

  join_thresh #(.N(N)) u_thr (
    .latch_i(latch_q),
    .fire_o (fire_now)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) join_q <= 1'b0;
    else         join_q <= fire_now;
  end
  assign join_o = join_q;

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&latch_q) |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

  // R3
  full_fires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&latch_q) |=> join_o);

  // R4
  partial_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&latch_q) |=> !join_o);

  // R5 R6
  clear_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&latch_q) |=> (latch_q == $past(done_i)));
endmodule

// File: tb/join_barrier_tb.sv
`timescale 1ns/1ps
module join_barrier_tb;
  localparam int N = 4;
  localparam logic [N-1:0] ALL = {N{1'b1}};

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [N-1:0] start_o;
  logic [N-1:0] done_i = '0;
  logic         join_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [N-1:0] m_lat = '0;
  logic         m_join = 1'b0;

  always #2 clk_i = ~clk_i;

  join_barrier #(.N(N)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .start_o(start_o), .done_i(done_i), .join_o(join_o)
  );

  function automatic logic model_fire(input logic [N-1:0] l);
    int s;
    s = -(N - 1);
    for (int k = 0; k < N; k++) s += int'(l[k]);
    return s >= 1;
  endfunction

  function automatic logic [N-1:0] model_next(input logic [N-1:0] l, input logic [N-1:0] d);
    return model_fire(l) ? d : (l | d);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s join_o act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input string tag, input logic [N-1:0] d, input logic s);
    done_i  = d;
    start_i = s;
    #0.5;
    n_run++;
    if (start_o !== {N{s}}) begin
      n_fail++;
      $display("FAIL R8 start_o act=%b exp=%b", start_o, {N{s}});
    end
    @(posedge clk_i);
    m_join = model_fire(m_lat);
    m_lat  = model_next(m_lat, d);
    @(negedge clk_i);
    check(tag, join_o, m_join);
    done_i  = '0;
    start_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk_i);
    check("R1 in reset", join_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step("R1 idle", '0, 1'b0);

    // R8 start fan-out
    step("R8", '0, 1'b1);

    // R2 R4: arrivals out of order with gaps, N-1 never fire
    step("R2 a", 4'b0100, 1'b0);
    step("R4 gap", '0, 1'b0);
    step("R2 b", 4'b0001, 1'b0);
    step("R2 c", 4'b1000, 1'b0);
    for (int k = 0; k < 5; k++) step("R4 wait N-1", '0, 1'b0);
    // R3: last arrival then pulse timing
    step("R3 last in", 4'b0010, 1'b0);
    step("R3 pulse", '0, 1'b0);
    step("R3 one cycle", '0, 1'b0);

    // R5: N-1 after fire does not fire
    step("R5 a", 4'b0111, 1'b0);
    for (int k = 0; k < 3; k++) step("R5 wait", '0, 1'b0);

    // R7: repeats on latched input
    step("R7 repeat", 4'b0001, 1'b0);
    step("R7 repeat2", 4'b0011, 1'b0);
    step("R7 complete", 4'b1000, 1'b0);
    step("R7 fire", '0, 1'b0);
    step("R7 one pulse", '0, 1'b0);
    step("R7 next a", 4'b1110, 1'b0);
    step("R7 no carry", '0, 1'b0);
    step("R7 last", 4'b0001, 1'b0);
    step("R7 fire2", '0, 1'b0);

    // R6: done on firing edge kept
    step("R6 full", ALL, 1'b0);
    step("R6 coincide", 4'b0101, 1'b0);
    step("R6 rest", 4'b1010, 1'b0);
    step("R6 fire again", '0, 1'b0);
    step("R6 tail", '0, 1'b0);

    // R1: mid-round reset discards arrivals
    step("R1 part", 4'b0111, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 async", join_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_lat = '0; m_join = 1'b0;
    step("R1 after", 4'b1000, 1'b0);
    step("R1 no fire", '0, 1'b0);
    step("R1 refill", 4'b0111, 1'b0);
    step("R1 fire", '0, 1'b0);

    // random phase
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] d;
      for (int k = 0; k < N; k++) d[k] = (($urandom % 3) == 0);
      step("R2 R3 R5 R6 R7 random", d, ($urandom % 8) == 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule